// File: doc/BRIEF.md
# Indirect Configuration Register Bridge

This block gives a 32-bit host register port access to a small bank of 16-bit MAC configuration registers that behave as slow storage. The host does not address the bank directly. It uses a command window and a data window. To read, the host writes the command window with the write flag clear. After a fixed number of clock cycles, the selected register's value appears in the low half of the data window. To write, the host first loads the data window. It then writes the command window with the write flag set, and the stored halfword is copied into the selected register when the access completes.

A status word reports whether an access is still running. It also holds a sticky overrun bit, which records a command that was dropped because it arrived while the bridge was busy. The bank holds three station-address halfwords, a mode word and an rx/tx control word. These are driven continuously to the MAC, and the 48-bit station address is presented with octet 0 in its most significant byte.

Top module: `indirect_reg_bridge`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, the status word reads 0, the data window reads 0, and `station_addr`, `mac_mode` and `mac_ctl` are all 0.
- R2: A host write to the command window (byte offset 0x0) with bit 15 clear starts a read of the register selected by bits 7:0. At completion, the data window holds that register in bits 15:0, and bits 31:16 read 0. A host data-window write that lands on the completion cycle is overwritten by the read result.
- R3: A host write to the command window with bit 15 set starts a write. At completion, the selected register receives the data-window value captured when the command was accepted. A later data-window write during the access does not change the value written.
- R4: `busy` and status bit 0 are 1 for exactly LATENCY cycles, starting on the cycle after the command is accepted. Register effects become visible when `busy` falls.
- R5: A command-window write while busy is ignored and sets the sticky overrun flag (status bit 1). A status write (offset 0x8) with bit 1 set clears the flag.
- R6: Index 0, 1 and 2 hold the station address. `station_addr[47:40]` is the high byte of index 0 (octet 0), `[39:32]` is its low byte, and indices 1 and 2 fill the lower bytes in the same way.
- R7: Index 3 drives `mac_mode` and index 4 drives `mac_ctl`. These outputs change only when an internal write completes.
- R8: Reads of an index above 4 return 0. Writes to such an index change no register.
- R9: `req_ready` is always 1. Every accepted host read returns `rsp_valid` on the next cycle. The data returned is taken from the state before the accepting clock edge, using this map: offset 0x0 gives the last accepted command (bit 15 is the flag, bits 7:0 the index), 0x4 gives the data window, and 0x8 gives the status word. Any other offset returns 0.
- R10: A command-window write accepted on the same clock edge at which an access completes is treated as arriving while busy. It is ignored and sets the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request ready (always 1) |
| req_write | input | 1 | 1 = host write, 0 = host read |
| req_addr | input | HOST_AW | Host byte offset |
| req_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| busy | output | 1 | Internal access in progress |
| station_addr | output | 48 | Station address, octet 0 in bits 47:40 |
| mac_mode | output | 16 | Mode register value |
| mac_ctl | output | 16 | Rx/tx control register value |

## Verification
The completion edge of an internal access can coincide with three host operations: a new command write, a status read, or a data-window write. The bench provokes each one by issuing the host request exactly LATENCY cycles after the command that started the access. The new command must be dropped and must raise overrun. The status read must still report busy. The data window must hold the read result rather than the host's value. A behavioural model, updated on the same edges, judges every cycle's outputs in addition to these directed checks.

// File: rtl/rib_pkg.sv
// Shared constants and types for the indirect configuration register bridge.
// Assumes a bank of five 16-bit registers selected by an 8-bit index.
package rib_pkg;
    localparam int REG_IDX_W    = 8;
    localparam int REG_W        = 16;
    localparam int HOST_DW      = 32;
    localparam int WFLAG_BIT    = 15;
    localparam int NUM_CFG_REGS = 5;
    localparam int STA_WORDS    = 3;

    localparam int IDX_MODE = 3;
    localparam int IDX_CTL  = 4;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_OVR_BIT  = 1;

    typedef enum logic [1:0] {
        WIN_CMD  = 2'd0,
        WIN_DATA = 2'd1,
        WIN_STAT = 2'd2,
        WIN_NONE = 2'd3
    } win_e;

    typedef struct packed {
        logic                 wr;
        logic [REG_IDX_W-1:0] idx;
    } cmd_t;
endpackage

// File: rtl/rib_host_port.sv
// Host side of the bridge: decodes the three windows, holds the data window,
// the last accepted command and the sticky overrun flag, and returns read
// data one cycle after an accepted read. Assumes one request per cycle.
module rib_host_port
    import rib_pkg::*;
#(
    parameter int HOST_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [HOST_AW-1:0] req_addr,
    input  logic [HOST_DW-1:0] req_wdata,
    input  logic               busy,
    input  logic               rd_load,
    input  logic [REG_W-1:0]   rd_value,
    output logic               start,
    output cmd_t               new_cmd,
    output logic [REG_W-1:0]   data_win,
    output logic               ovr,
    output logic               rsp_valid,
    output logic [HOST_DW-1:0] rsp_data
);
    win_e win;
    cmd_t last_cmd;
    logic wr_acc;
    logic rd_acc;
    logic cmd_hit;
    logic ovr_clr;
    logic [HOST_DW-1:0] rd_mux;
    logic unused_bits;

    assign unused_bits = ^{req_addr[1:0], req_wdata[HOST_DW-1:REG_W], req_wdata[14:REG_IDX_W]};

    // Window decode: only offsets 0x0, 0x4 and 0x8 are populated.
    always_comb begin
        win = WIN_NONE;
        if (req_addr[HOST_AW-1:4] == '0) begin
            case (req_addr[3:2])
                2'd0:    win = WIN_CMD;
                2'd1:    win = WIN_DATA;
                2'd2:    win = WIN_STAT;
                default: win = WIN_NONE;
            endcase
        end
    end

    assign wr_acc  = req_valid && req_write;
    assign rd_acc  = req_valid && !req_write;
    assign cmd_hit = wr_acc && (win == WIN_CMD);
    assign start   = cmd_hit && !busy;
    assign ovr_clr = wr_acc && (win == WIN_STAT) && req_wdata[STAT_OVR_BIT];
    assign new_cmd = '{wr: req_wdata[WFLAG_BIT], idx: req_wdata[REG_IDX_W-1:0]};

    // Read data for the addressed window, from pre-edge state.
    always_comb begin
        case (win)
            WIN_CMD:  rd_mux = {16'b0, last_cmd.wr, 7'b0, last_cmd.idx};
            WIN_DATA: rd_mux = {16'b0, data_win};
            WIN_STAT: rd_mux = {30'b0, ovr, busy};
            default:  rd_mux = '0;
        endcase
    end

    // Data window: a completing read overrides a host write on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                              data_win <= '0;
        else if (rd_load)                        data_win <= rd_value;
        else if (wr_acc && (win == WIN_DATA))    data_win <= req_wdata[REG_W-1:0];
    end

    // Last accepted command, echoed through the command window.
    always_ff @(posedge clk) begin
        if (!rst_n)     last_cmd <= '0;
        else if (start) last_cmd <= new_cmd;
    end

    // Sticky overrun flag: set by a command while busy, cleared by status write.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovr <= 1'b0;
        else if (cmd_hit && busy)  ovr <= 1'b1;
        else if (ovr_clr)          ovr <= 1'b0;
    end

    // Read response register, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_acc;
            if (rd_acc) rsp_data <= rd_mux;
        end
    end
endmodule

// File: rtl/rib_seq.sv
// Access sequencer: holds a started command for LATENCY cycles, then issues
// one bank write or one read-load strobe. Assumes start only arrives idle.
module rib_seq
    import rib_pkg::*;
#(
    parameter int LATENCY = 50
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  cmd_t                 new_cmd,
    input  logic [REG_W-1:0]     data_win,
    output logic                 busy,
    output logic                 bank_we,
    output logic                 rd_load,
    output logic [REG_IDX_W-1:0] bank_idx,
    output logic [REG_W-1:0]     bank_wdata
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    logic [CNT_W-1:0] cnt;
    cmd_t             cur;
    logic [REG_W-1:0] snap;
    logic             done;

    assign done       = busy && (cnt == '0);
    assign bank_we    = done && cur.wr;
    assign rd_load    = done && !cur.wr;
    assign bank_idx   = cur.idx;
    assign bank_wdata = snap;

    // Latency countdown with command and write-data capture at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            cur  <= '0;
            snap <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(LATENCY - 1);
            cur  <= new_cmd;
            snap <= data_win;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/rib_bank.sv
// Configuration register bank: NUM_REGS halfwords with one write port and one
// combinational read port sharing an index; unmapped indices read zero.
module rib_bank
    import rib_pkg::*;
#(
    parameter int NUM_REGS = NUM_CFG_REGS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    output logic [STA_WORDS*REG_W-1:0] station_addr,
    output logic [REG_W-1:0]     mode_q,
    output logic [REG_W-1:0]     ctl_q
);
    logic [REG_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // One register, written when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                               regs[g] <= '0;
            else if (we && (idx == REG_IDX_W'(g)))    regs[g] <= wdata;
        end
    end

    // Read port: selected register or zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (idx == REG_IDX_W'(i)) rdata = regs[i];
    end

    for (genvar s = 0; s < STA_WORDS; s++) begin : g_sta
        assign station_addr[(STA_WORDS-s)*REG_W-1 -: REG_W] = regs[s];
    end

    assign mode_q = regs[IDX_MODE];
    assign ctl_q  = regs[IDX_CTL];
endmodule

// File: rtl/indirect_reg_bridge.sv
// Top of the bridge: host port, sequencer and bank. Assumes a single clock
// domain; the host may issue one request per cycle and is never stalled.
module indirect_reg_bridge
    import rib_pkg::*;
#(
    parameter int LATENCY = 50,
    parameter int HOST_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [HOST_AW-1:0] req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_data,
    output logic               busy,
    output logic [47:0]        station_addr,
    output logic [15:0]        mac_mode,
    output logic [15:0]        mac_ctl
);
    logic                 start_w;
    cmd_t                 cmd_w;
    logic [REG_W-1:0]     win_w;
    logic                 ovr_w;
    logic                 we_w;
    logic                 rd_load_w;
    logic [REG_IDX_W-1:0] idx_w;
    logic [REG_W-1:0]     wdata_w;
    logic [REG_W-1:0]     rdata_w;

    assign req_ready = 1'b1;

    rib_host_port #(.HOST_AW(HOST_AW)) u_host (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rd_load(rd_load_w), .rd_value(rdata_w),
        .start(start_w), .new_cmd(cmd_w), .data_win(win_w), .ovr(ovr_w),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    rib_seq #(.LATENCY(LATENCY)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .new_cmd(cmd_w), .data_win(win_w),
        .busy(busy), .bank_we(we_w), .rd_load(rd_load_w),
        .bank_idx(idx_w), .bank_wdata(wdata_w)
    );

    rib_bank #(.NUM_REGS(NUM_CFG_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .we(we_w), .idx(idx_w), .wdata(wdata_w), .rdata(rdata_w),
        .station_addr(station_addr), .mode_q(mac_mode), .ctl_q(mac_ctl)
    );
endmodule

// File: rtl/rib_checker.sv
// Property checker for the bridge, bound onto the top module. Assumes reset
// is held for at least two cycles.
module rib_checker #(
    parameter int LATENCY = 50,
    parameter int HOST_AW = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [HOST_AW-1:0] req_addr,
    input logic               wdata_clr_bit,
    input logic               rsp_valid,
    input logic               busy,
    input logic               start,
    input logic               ovr,
    input logic [47:0]        station_addr,
    input logic [15:0]        mac_mode,
    input logic [15:0]        mac_ctl
);
    int   run_q;
    logic cmd_wr;
    logic clr_req;

    assign cmd_wr  = req_valid && req_write && (req_addr == HOST_AW'(0));
    assign clr_req = req_valid && req_write && (req_addr == HOST_AW'(8)) && wdata_clr_bit;

    // Count consecutive busy cycles to measure access length.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    // R4
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == LATENCY));

    // R5
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr_req) |=> ovr);

    // R5
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> ovr);

    // R9
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R9
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R7 (and R6): configuration outputs move only on a completing access
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable({station_addr, mac_mode, mac_ctl}));
endmodule

bind indirect_reg_bridge rib_checker #(.LATENCY(LATENCY), .HOST_AW(HOST_AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .wdata_clr_bit(req_wdata[1]), .rsp_valid(rsp_valid),
    .busy(busy), .start(start_w), .ovr(ovr_w),
    .station_addr(station_addr), .mac_mode(mac_mode), .mac_ctl(mac_ctl)
);

// File: tb/indirect_reg_bridge_tb.sv
module indirect_reg_bridge_tb;
    localparam int LAT = 50;
    localparam int AW  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_data;
    logic          busy;
    logic [47:0]   station_addr;
    logic [15:0]   mac_mode;
    logic [15:0]   mac_ctl;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    indirect_reg_bridge #(.LATENCY(LAT), .HOST_AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
        .station_addr(station_addr), .mac_mode(mac_mode), .mac_ctl(mac_ctl)
    );

    always #10 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_reg [5];
    int m_win, m_busy, m_cnt, m_wr, m_idx, m_snap, m_ovr, m_last, m_rspv, m_rspd;

    always @(posedge clk) begin
        int o_busy, o_cnt, o_win, w, a, d;
        if (!rst_n) begin
            foreach (m_reg[i]) m_reg[i] = 0;
            m_win = 0; m_busy = 0; m_cnt = 0; m_wr = 0; m_idx = 0;
            m_snap = 0; m_ovr = 0; m_last = 0; m_rspv = 0; m_rspd = 0;
        end else begin
            o_busy = m_busy; o_cnt = m_cnt; o_win = m_win;
            a = int'(req_addr);
            w = (a < 16) ? (a >> 2) : 3;
            d = int'(req_wdata);
            m_rspv = (req_valid && !req_write) ? 1 : 0;
            if (m_rspv == 1) begin
                case (w)
                    0:       m_rspd = m_last;
                    1:       m_rspd = m_win;
                    2:       m_rspd = (m_ovr << 1) | m_busy;
                    default: m_rspd = 0;
                endcase
            end
            if (req_valid && req_write) begin
                case (w)
                    0: if (o_busy == 1) m_ovr = 1;
                       else begin
                           m_busy = 1; m_cnt = LAT;
                           m_wr = (d >> 15) & 1; m_idx = d & 255;
                           m_snap = o_win;
                           m_last = (m_wr << 15) | m_idx;
                       end
                    1: m_win = d & 16'hFFFF;
                    2: if (((d >> 1) & 1) == 1) m_ovr = 0;
                    default: ;
                endcase
            end
            if (o_busy == 1) begin
                if (o_cnt == 1) begin
                    m_busy = 0;
                    if (m_wr == 1) begin
                        if (m_idx < 5) m_reg[m_idx] = m_snap;
                    end else begin
                        m_win = (m_idx < 5) ? m_reg[m_idx] : 0;
                    end
                end else begin
                    m_cnt = o_cnt - 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 busy", busy, m_busy);
            chk("R6 station_addr", station_addr,
                {m_reg[0][15:0], m_reg[1][15:0], m_reg[2][15:0]});
            chk("R7 mac_mode", mac_mode, m_reg[3] & 16'hFFFF);
            chk("R7 mac_ctl", mac_ctl, m_reg[4] & 16'hFFFF);
            chk("R9 rsp_valid", rsp_valid, m_rspv);
            if (rsp_valid) chk("R9 rsp_data", rsp_data, m_rspd);
        end
    end

    // ---------------- host tasks (called at a negedge) ----------------
    task automatic host_wr(input int off, input logic [31:0] data);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = AW'(off); req_wdata = data;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic host_rd(input int off, output logic [31:0] data);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(off);
        @(posedge clk); @(negedge clk);
        data = rsp_data;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic reg_write(input int idx, input logic [15:0] val);
        host_wr(4, {16'hFFFF, val});
        host_wr(0, 32'h8000 | idx);
        wait_idle();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 station_addr", station_addr, 0);
        chk("R9 req_ready", req_ready, 1);
        host_rd(8, r); chk("R1 status", r, 0);
        host_rd(4, r); chk("R1 data window", r, 0);

        // R3/R6 station address via writes, octet order
        reg_write(0, 16'hACDE);
        reg_write(1, 16'h4800);
        reg_write(2, 16'h0080);
        chk("R6 station_addr order", station_addr, 48'hACDE_4800_0080);
        chk("R6 octet0", station_addr[47:40], 8'hAC);
        reg_write(3, 16'h1234);
        reg_write(4, 16'hBEEF);
        chk("R7 mode", mac_mode, 16'h1234);
        chk("R7 ctl", mac_ctl, 16'hBEEF);

        // R2 read of index 1, data window prefilled
        host_wr(4, 32'h5555);
        host_wr(0, 32'h0001);
        wait_idle();
        host_rd(4, r); chk("R2 read idx1", r, 32'h4800);

        // R8 unmapped write and read
        host_wr(4, 32'h7777);
        host_wr(0, 32'h8009);
        wait_idle();
        chk("R8 station unchanged", station_addr, 48'hACDE_4800_0080);
        chk("R8 ctl unchanged", mac_ctl, 16'hBEEF);
        host_wr(0, 32'h0009);
        wait_idle();
        host_rd(4, r); chk("R8 unmapped read", r, 0);

        // R5 overrun while busy
        host_wr(0, 32'h0000);
        host_wr(0, 32'h8004);
        host_rd(8, r); chk("R5 status busy+ovr", r, 3);
        wait_idle();
        host_rd(4, r); chk("R5 first command result", r, 32'hACDE);
        chk("R5 ignored write", mac_ctl, 16'hBEEF);
        host_rd(8, r); chk("R5 sticky", r, 2);
        host_wr(8, 32'h2);
        host_rd(8, r); chk("R5 cleared", r, 0);

        // R10 command on the completion edge
        host_wr(0, 32'h0003);
        repeat (LAT - 1) @(negedge clk);
        host_wr(0, 32'h8004);
        chk("R10 idle after completion", busy, 0);
        host_rd(8, r); chk("R10 overrun set", r, 2);
        host_rd(4, r); chk("R10 read result", r, 32'h1234);
        host_rd(0, r); chk("R10 last command", r, 32'h0003);
        host_wr(8, 32'h2);

        // R9 status read on the completion edge sees busy
        host_wr(0, 32'h0002);
        repeat (LAT - 1) @(negedge clk);
        host_rd(8, r); chk("R9 status at completion", r, 1);
        chk("R4 busy fell", busy, 0);
        host_rd(4, r); chk("R2 read idx2", r, 32'h0080);

        // R2 data-window write lost at read completion
        host_wr(0, 32'h0004);
        repeat (LAT - 1) @(negedge clk);
        host_wr(4, 32'h1111);
        host_rd(4, r); chk("R2 completion wins", r, 32'hBEEF);

        // R3 write uses data captured at start
        host_wr(4, 32'hAAAA);
        host_wr(0, 32'h8003);
        host_wr(4, 32'h5555);
        wait_idle();
        chk("R3 snapshot", mac_mode, 16'hAAAA);
        host_rd(4, r); chk("R3 window kept", r, 32'h5555);

        // R9 map: unpopulated offsets and command echo
        host_rd(12, r); chk("R9 offset 0xC", r, 0);
        host_rd(16, r); chk("R9 offset 0x10", r, 0);
        host_rd(0, r);  chk("R9 command echo", r, 32'h8003);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule